// File: doc/BRIEF.md
# Converter Serial Result Framer

This block sends each conversion result of a successive-approximation converter over a three-wire serial link: a serial clock, an active-low frame strobe and a data line. Transmission overlaps the conversion. A frame opens when the conversion starts. The result bits are then emitted one serial period after the SAR core resolves each of them, so the host holds the complete word at the moment the conversion ends.

The serial clock is the converter master clock divided by two. A mode input selects one of two clock behaviours. In free-running mode the clock toggles at all times. In gated mode the clock line is released between frames, so several converters can share one bus. All three lines are open-drain. The block drives only pull-low enables, and a released line is high through its external pull-up.

Top module: `serial_result_framer`

## Requirements
- R1: A frame holds exactly 16 bit slots. The first two carry 0. The next 14 carry the result, most significant bit first. The receiver takes each slot on a falling edge of the serial clock while the strobe is low.
- R2: The strobe is pulled low at the master clock edge that accepts a start, with the serial clock line high at that point. It is released at the serial clock rising transition that follows the sixteenth falling edge. That transition is 32 master clock edges after the strobe was pulled low.
- R3: Within a frame, the data line changes only at rising transitions of the serial clock (line released).
- R4: The serial clock has a period of two master clock cycles, one high and one low. Falling edges inside a frame are exactly two master cycles apart.
- R5: When `cont_mode` is 1 (free-running), the serial clock line changes level on every master clock edge, during frames and between them. In this mode a start is accepted only at an edge where the line goes high, so acceptance can wait one extra cycle.
- R6: When `cont_mode` is 0 (gated), the serial clock is released outside frames. In gated mode a start is accepted at the next master clock edge.
- R7: All outputs are pull-low enables (1 = pull low). The data enable is 1 only inside a frame and only for a 0 bit. Outside a frame, the strobe and data are released.
- R8: Result bit i is taken from the i-th `sar_valid` decision (`sar_bit`) of the current frame. It is sent from the first serial clock rising transition after the edge that registered it. It is never sent before it has been registered.
- R9: A start that arrives while a frame is in progress is ignored. The frame finishes unchanged, and no second frame follows it.
- R10: While reset is held, and directly after it, all three lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Conversion start request, one cycle high |
| sar_valid | input | 1 | SAR core resolved one more bit this cycle |
| sar_bit | input | 1 | Value of the bit just resolved, MSB first |
| cont_mode | input | 1 | 1 = free-running serial clock, 0 = gated |
| sclk_pull | output | 1 | Pull-low enable of the serial clock line |
| sstrb_pull | output | 1 | Pull-low enable of the frame strobe line |
| sdata_pull | output | 1 | Pull-low enable of the serial data line |

## Verification
The hardest case to reach is a start in free-running mode that lands while the clock line is high. The framer must then hold the request for one cycle so the frame begins on a rising phase. The bench reaches it by sweeping the idle delay before each start over both parities, so every result pattern is sent from both alignments. It checks that the strobe opens with the clock high and that the stream still decodes correctly. The other hard case is a start request during an active frame. A second pulse is injected mid-frame, and the bench then checks that the decoded word is intact and that the strobe stays released afterwards.

// File: rtl/srf_pkg.sv
package srf_pkg;

    localparam int RES_W_DEF  = 14;
    localparam int LEAD_W_DEF = 2;

    typedef enum logic {
        MODE_GATED = 1'b0,
        MODE_CONT  = 1'b1
    } clk_mode_e;

    // pull-low enables of the three open-drain lines
    typedef struct packed {
        logic sclk;
        logic strobe;
        logic data;
    } line_pull_s;

    // value of frame slot idx: lead zeros, then result MSB first
    function automatic logic slot_value(input logic [31:0] res, input int idx,
                                        input int lead, input int res_w);
        int pos;
        if (idx < lead) return 1'b0;
        pos = res_w - 1 - (idx - lead);
        if (pos < 0 || pos > 31) return 1'b0;
        return res[pos];
    endfunction

endpackage

// File: rtl/srf_phase_gen.sv
module srf_phase_gen (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic open_frame,
    output logic phase_hi
);
    always_ff @(posedge clk) begin
        if (rst)             phase_hi <= 1'b1;
        else if (open_frame) phase_hi <= 1'b1;
        else if (run)        phase_hi <= ~phase_hi;
        else                 phase_hi <= 1'b1;
    end
endmodule

// File: rtl/srf_capture.sv
module srf_capture #(
    parameter int RES_W = 14,
    localparam int CNT_W = $clog2(RES_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic             dec_valid,
    input  logic             dec_bit,
    output logic [RES_W-1:0] result,
    output logic [CNT_W-1:0] dec_count
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(RES_W);

    logic take;
    assign take = enable && dec_valid && (dec_count != FULL);

    always_ff @(posedge clk) begin
        if (rst || clear) dec_count <= '0;
        else if (take)    dec_count <= dec_count + 1'b1;
    end

    for (genvar g = 0; g < RES_W; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                result[RES_W-1-g] <= 1'b0;
            else if (take && dec_count == CNT_W'(g))
                result[RES_W-1-g] <= dec_bit;
        end
    end
endmodule

// File: rtl/srf_sequencer.sv
module srf_sequencer #(
    parameter int RES_W  = 14,
    parameter int LEAD_W = 2,
    localparam int FRAME_W = RES_W + LEAD_W,
    localparam int IDX_W   = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cont,
    input  logic             phase_hi,
    input  logic [RES_W-1:0] result,
    output logic             open_frame,
    output logic             in_frame,
    output logic [IDX_W-1:0] slot_idx,
    output logic             tx_bit
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

    logic pending;
    logic rise_now;
    logic [31:0] res_wide;

    assign res_wide   = 32'(result);
    assign open_frame = !in_frame && (start || pending) && (!cont || !phase_hi);
    assign rise_now   = in_frame && !phase_hi;

    always_ff @(posedge clk) begin
        if (rst || in_frame || open_frame) pending <= 1'b0;
        else if (start)                    pending <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            slot_idx <= '0;
            tx_bit   <= 1'b1;
        end else if (open_frame) begin
            in_frame <= 1'b1;
            slot_idx <= '0;
            tx_bit   <= srf_pkg::slot_value(res_wide, 0, LEAD_W, RES_W);
        end else if (rise_now) begin
            if (slot_idx == LAST) begin
                in_frame <= 1'b0;
                tx_bit   <= 1'b1;
            end else begin
                slot_idx <= slot_idx + 1'b1;
                tx_bit   <= srf_pkg::slot_value(res_wide, int'(slot_idx) + 1,
                                                LEAD_W, RES_W);
            end
        end
    end
endmodule

// File: rtl/serial_result_framer.sv
module serial_result_framer #(
    parameter int RES_W  = srf_pkg::RES_W_DEF,
    parameter int LEAD_W = srf_pkg::LEAD_W_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_start,
    input  logic sar_valid,
    input  logic sar_bit,
    input  logic cont_mode,
    output logic sclk_pull,
    output logic sstrb_pull,
    output logic sdata_pull
);
    localparam int FRAME_W = RES_W + LEAD_W;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int CNT_W   = $clog2(RES_W + 1);

    srf_pkg::clk_mode_e mode;
    srf_pkg::line_pull_s pulls;

    logic             phase_hi;
    logic             open_frame;
    logic             in_frame;
    logic [IDX_W-1:0] slot_idx;
    logic             tx_bit;
    logic [RES_W-1:0] result;
    logic [CNT_W-1:0] dec_count;

    assign mode = srf_pkg::clk_mode_e'(cont_mode);

    srf_phase_gen u_phase (
        .clk(clk), .rst(rst),
        .run(mode == srf_pkg::MODE_CONT || in_frame),
        .open_frame(open_frame),
        .phase_hi(phase_hi)
    );

    srf_capture #(.RES_W(RES_W)) u_capture (
        .clk(clk), .rst(rst),
        .clear(open_frame), .enable(in_frame),
        .dec_valid(sar_valid), .dec_bit(sar_bit),
        .result(result), .dec_count(dec_count)
    );

    srf_sequencer #(.RES_W(RES_W), .LEAD_W(LEAD_W)) u_seq (
        .clk(clk), .rst(rst),
        .start(conv_start), .cont(mode == srf_pkg::MODE_CONT),
        .phase_hi(phase_hi), .result(result),
        .open_frame(open_frame), .in_frame(in_frame),
        .slot_idx(slot_idx), .tx_bit(tx_bit)
    );

    always_comb begin
        pulls.sclk   = !phase_hi && (mode == srf_pkg::MODE_CONT || in_frame);
        pulls.strobe = in_frame;
        pulls.data   = in_frame && !tx_bit;
    end

    assign sclk_pull  = pulls.sclk;
    assign sstrb_pull = pulls.strobe;
    assign sdata_pull = pulls.data;
endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
    parameter int RES_W  = 14,
    parameter int LEAD_W = 2,
    localparam int FRAME_W = RES_W + LEAD_W,
    localparam int IDX_W   = $clog2(FRAME_W),
    localparam int CNT_W   = $clog2(RES_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cont_mode,
    input logic             sclk_pull,
    input logic             sstrb_pull,
    input logic             sdata_pull,
    input logic             in_frame,
    input logic [IDX_W-1:0] slot_idx,
    input logic [CNT_W-1:0] dec_count
);
    logic       prev_line_hi;
    logic [7:0] fall_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_line_hi <= 1'b1;
            fall_cnt     <= '0;
        end else begin
            prev_line_hi <= !sclk_pull;
            if (!sstrb_pull)                     fall_cnt <= '0;
            else if (prev_line_hi && sclk_pull)  fall_cnt <= fall_cnt + 1'b1;
        end
    end

    assert_data_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
        sdata_pull |-> sstrb_pull);

    assert_strobe_state_R7: assert property (@(posedge clk) disable iff (rst)
        sstrb_pull == in_frame);

    assert_free_clock_R5: assert property (@(posedge clk) disable iff (rst)
        (cont_mode && $past(cont_mode) && !$past(rst)) |-> (sclk_pull != $past(sclk_pull)));

    assert_data_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (sstrb_pull && $past(sstrb_pull) && !($past(sclk_pull) && !sclk_pull))
        |-> $stable(sdata_pull));

    assert_gated_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!cont_mode && !sstrb_pull) |-> !sclk_pull);

    assert_frame_len_R1: assert property (@(posedge clk) disable iff (rst)
        fall_cnt <= 8'(FRAME_W));

    assert_bit_resolved_R8: assert property (@(posedge clk) disable iff (rst)
        (sstrb_pull && $past(sstrb_pull) && $past(sclk_pull) && !sclk_pull
         && int'(slot_idx) >= LEAD_W)
        |-> (int'($past(dec_count)) > int'(slot_idx) - LEAD_W));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (in_frame && $past(in_frame))
        |-> (slot_idx == $past(slot_idx) || slot_idx == $past(slot_idx) + 1'b1));

    assert_reset_release_R10: assert property (@(posedge clk)
        $past(rst) |-> (!sstrb_pull && !sdata_pull));
endmodule

bind serial_result_framer srf_checker #(.RES_W(RES_W), .LEAD_W(LEAD_W)) u_chk (
    .clk(clk), .rst(rst), .cont_mode(cont_mode),
    .sclk_pull(sclk_pull), .sstrb_pull(sstrb_pull), .sdata_pull(sdata_pull),
    .in_frame(in_frame), .slot_idx(slot_idx), .dec_count(dec_count)
);

// File: tb/test_serial_result_framer.sv
module test_serial_result_framer;
    localparam int RES_W = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv_start = 1'b0;
    logic sar_valid = 1'b0;
    logic sar_bit = 1'b0;
    logic cont_mode = 1'b0;
    logic sclk_pull, sstrb_pull, sdata_pull;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_result_framer i_serial_result_framer (
        .clk(clk), .rst(rst), .conv_start(conv_start),
        .sar_valid(sar_valid), .sar_bit(sar_bit), .cont_mode(cont_mode),
        .sclk_pull(sclk_pull), .sstrb_pull(sstrb_pull), .sdata_pull(sdata_pull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one frame: start after 'delay' idle cycles, optionally pulse start mid-frame
    task automatic run_frame(input logic [RES_W-1:0] value, input bit cont,
                             input int delay, input bit restart);
        int lat, k, falls, last_fall, gap_bad;
        logic [15:0] got;
        bit prev_hi, cur_hi;
        cont_mode = cont;
        for (int d = 0; d < delay; d++) @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        lat = 1;
        while (!sstrb_pull && lat < 4) begin
            @(negedge clk);
            lat++;
        end
        if (!sstrb_pull) lat = 99;
        // R2 / R6 / R5: acceptance latency and clock high at frame open
        if (cont) chk(lat == 1 || lat == 2, "R5 start latency", lat, 2);
        else      chk(lat == 1, "R6 start latency", lat, 1);
        chk(!sclk_pull, "R2 clock high at strobe", int'(sclk_pull), 0);
        got = '0; falls = 0; last_fall = -10; gap_bad = 0;
        prev_hi = 1'b1; k = 0;
        while (k < 40) begin
            // R8: drive decision i so it registers in frame slot i+1
            if (k >= 2 && k % 2 == 0 && (k - 2) / 2 < RES_W) begin
                sar_valid = 1'b1;
                sar_bit   = value[RES_W-1-(k-2)/2];
            end else begin
                sar_valid = 1'b0;
            end
            conv_start = restart && (k == 9);
            @(negedge clk);
            k++;
            if (!sstrb_pull) break;
            cur_hi = !sclk_pull;
            if (prev_hi && !cur_hi) begin
                got = {got[14:0], !sdata_pull};
                if (falls > 0 && k - last_fall != 2) gap_bad++;
                last_fall = k;
                falls++;
            end
            prev_hi = cur_hi;
        end
        sar_valid = 1'b0;
        conv_start = 1'b0;
        chk(got == {2'b00, value}, restart ? "R9 frame intact" : "R1 R8 frame content",
            int'(got), int'({2'b00, value}));
        chk(falls == 16, "R1 falling edge count", falls, 16);
        chk(gap_bad == 0, "R4 serial period", gap_bad, 0);
        chk(k == 32, "R2 strobe release time", k, 32);
        chk(!sdata_pull && !sstrb_pull, "R7 released after frame",
            int'({sstrb_pull, sdata_pull}), 0);
        // idle behaviour
        begin
            int toggles = 0, held = 0, strobe_seen = 0;
            bit p = !sclk_pull;
            for (int t = 0; t < 6; t++) begin
                @(negedge clk);
                if ((!sclk_pull) != p) toggles++;
                if (sclk_pull) held++;
                if (sstrb_pull) strobe_seen++;
                p = !sclk_pull;
            end
            if (cont) chk(toggles == 6, "R5 free clock idle", toggles, 6);
            else      chk(held == 0, "R6 gated clock released", held, 0);
            if (restart) chk(strobe_seen == 0, "R9 no extra frame", strobe_seen, 0);
        end
    endtask

    initial begin
        for (int c = 0; c < 3; c++) @(negedge clk);
        chk(!sclk_pull && !sstrb_pull && !sdata_pull, "R10 lines in reset",
            int'({sclk_pull, sstrb_pull, sdata_pull}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sstrb_pull && !sdata_pull, "R10 idle after reset",
            int'({sstrb_pull, sdata_pull}), 0);
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int b = 0; b < RES_W; b++)
                    run_frame(RES_W'(1) << b, m[0], d, 1'b0);
                for (int b = 0; b < RES_W; b++)
                    run_frame(~(RES_W'(1) << b), m[0], d, 1'b0);
                run_frame('0, m[0], d, 1'b0);
                run_frame('1, m[0], d, 1'b0);
                run_frame(14'h2AAA, m[0], d, 1'b0);
                run_frame(14'h1555, m[0], d, 1'b0);
                run_frame(14'h2000, m[0], d, 1'b1);
                run_frame(14'h1FFF, m[0], d, 1'b1);
            end
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule